// File: doc/BRIEF.md
# Power-of-Two Count-Enable Prescaler

This block turns the system clock into four count-enable strobes for a bank of timer channels. A single free-running 15-bit up-counter is shared by all four outputs. Each output has its own select field in a 16-bit control register. Each output therefore runs at a power-of-two fraction of the system clock, and all outputs keep the same counter phase.

Every output is an enable pulse in the system clock domain. It is never a derived clock. It is high for one system-clock period and appears once per selected period. Two outputs have 4-bit select codes that cover ratios from 1 to 32768. The other two have 2-bit codes that cover four coarse ratios from 256 to 16384.

Software writes the control register through a simple synchronous port and reads it back from `rd_data_o`. A halt input freezes the counter and silences every strobe.

Top module: `clk_strobe_gen`

## Requirements
- R1: After a synchronous active-low reset, the control register reads 16'h0000 and the shared counter is zero.
- R2: `tick_o[0]` is selected by register bits 3:0 and `tick_o[1]` by bits 7:4. A code value n gives a divide ratio of 2^n.
- R3: `tick_o[2]` is selected by bits 9:8 and `tick_o[3]` by bits 13:12. A code value n gives a divide ratio of 2^(2n+8), which is 256, 1024, 4096 or 16384.
- R4: Bits 15, 14, 11 and 10 are reserved. They always read as zero, and writing ones to them changes nothing.
- R5: For a ratio 2^e with e ≥ 1, a strobe is high in exactly the cycles in which the low e bits of the counter are all ones. It is therefore one cycle wide and occurs once every 2^e unhalted cycles.
- R6: A select code of 0 keeps its strobe high on every unhalted cycle.
- R7: A write changes the register, and so the strobes, from the next cycle on. A write does not reset the counter, so the new ratio uses the existing counter phase.
- R8: While `halt_i` is high, the counter holds its value and every strobe is low in that same cycle.
- R9: `rd_data_o` always shows the current register contents and stays unchanged in cycles without a write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| halt_i | input | 1 | Freeze counter and force all strobes low |
| wr_en_i | input | 1 | Register write enable |
| wr_data_i | input | 16 | Register write data |
| rd_data_o | output | 16 | Register read-back (reserved bits zero) |
| tick_o | output | 4 | Count-enable strobes: [1:0] wide-coded, [3:2] narrow-coded |

## Verification
The bound assertions check several rules on every cycle:
- reserved bits read as zero;
- halt silences the strobes and freezes the counter;
- the counter advances by one when it is not halted;
- a code of 0 keeps its strobe high;
- a strobe never lasts two cycles in a row under an unchanged non-zero code;
- a write is visible one cycle later, and the register holds its value otherwise.

Only the bench scenarios can show the rest. They check the exact ratio for each code value on each field and the phase kept across a write. They also check the long periods at codes 15 and narrow code 3, which a scoreboard compares against a cycle-by-cycle model built from the requirements.

// File: rtl/strobe_pkg.sv
// Package: shared layout constants and helpers for the prescaler.
// Assumes a 16-bit register in which select fields start every 4 bits.
package strobe_pkg;

    localparam int REG_W         = 16;
    localparam int FIELD_PITCH   = 4;
    localparam int WIDE_BASE     = 0;
    localparam int NARROW_BASE   = 8;

    // Build the mask of writable register bits from the field layout.
    function automatic logic [REG_W-1:0] live_mask(
        input int wide_n,
        input int wide_cw,
        input int narrow_n,
        input int narrow_cw
    );
        logic [REG_W-1:0] m;
        m = '0;
        for (int i = 0; i < wide_n; i++) begin
            for (int b = 0; b < wide_cw; b++) begin
                m[WIDE_BASE + i*FIELD_PITCH + b] = 1'b1;
            end
        end
        for (int j = 0; j < narrow_n; j++) begin
            for (int b = 0; b < narrow_cw; b++) begin
                m[NARROW_BASE + j*FIELD_PITCH + b] = 1'b1;
            end
        end
        return m;
    endfunction

endpackage

// File: rtl/strobe_cfg_reg.sv
// Module: control register for the strobe selects.
// Bits that are not set in LIVE_MASK are never stored and always read as zero.
// Assumes a synchronous active-low reset.
module strobe_cfg_reg #(
    parameter int          REG_W     = 16,
    parameter logic [15:0] LIVE_MASK = 16'h33FF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] cfg_q
);

    localparam logic [REG_W-1:0] KEEP = REG_W'(LIVE_MASK);

    // Store the writable bits and clear the register on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en_i) begin
            cfg_q <= wr_data_i & KEEP;
        end
    end

endmodule

// File: rtl/strobe_phase_ctr.sv
// Module: shared free-running phase counter.
// It wraps modulo 2^CNT_W and holds its value while halted.
// Assumes a synchronous active-low reset.
module strobe_phase_ctr #(
    parameter int CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_i,
    output logic [CNT_W-1:0] cnt_q
);

    // Advance the counter by one on every unhalted cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!halt_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/strobe_tap.sv
// Module: decodes one select code into a one-cycle enable strobe.
// The exponent is code*SCALE+OFFSET.
// The strobe fires when that many low counter bits are all ones.
// An exponent of 0 fires on every cycle.
// Assumes CNT_W is at least the largest exponent.
module strobe_tap #(
    parameter int CNT_W  = 15,
    parameter int CODE_W = 4,
    parameter int SCALE  = 1,
    parameter int OFFSET = 0
) (
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic [CODE_W-1:0] code_i,
    input  logic              halt_i,
    output logic              tick_o
);

    localparam int EXP_W = $clog2(CNT_W + 1) + 1;

    logic [EXP_W-1:0] span;
    logic [CNT_W-1:0] low_mask;

    // Turn the select code into the number of counter bits to watch.
    always_comb begin
        span = EXP_W'(code_i) * EXP_W'(SCALE) + EXP_W'(OFFSET);
    end

    // Mark the watched counter bits.
    always_comb begin
        for (int b = 0; b < CNT_W; b++) begin
            low_mask[b] = (EXP_W'(b) < span);
        end
    end

    // Fire when every watched bit is one and the unit is not halted.
    always_comb begin
        tick_o = !halt_i && ((cnt_i & low_mask) == low_mask);
    end

endmodule

// File: rtl/clk_strobe_gen.sv
// Module: top of the power-of-two count-enable prescaler.
// One shared counter feeds WIDE_N taps with wide codes and NARROW_N taps with
// narrow codes. The strobes are enables in the clk domain, not clocks.
// Assumes a synchronous active-low reset.
module clk_strobe_gen
    import strobe_pkg::*;
#(
    parameter int CNT_W       = 15,
    parameter int WIDE_N      = 2,
    parameter int NARROW_N    = 2,
    parameter int WIDE_CW     = 4,
    parameter int NARROW_CW   = 2,
    parameter int NARROW_STEP = 2,
    parameter int NARROW_OFS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       halt_i,
    input  logic                       wr_en_i,
    input  logic [REG_W-1:0]           wr_data_i,
    output logic [REG_W-1:0]           rd_data_o,
    output logic [WIDE_N+NARROW_N-1:0] tick_o
);

    localparam logic [REG_W-1:0] LIVE = live_mask(WIDE_N, WIDE_CW, NARROW_N, NARROW_CW);

    logic [REG_W-1:0] cfg_q;
    logic [CNT_W-1:0] cnt_q;

    strobe_cfg_reg #(
        .REG_W     (REG_W),
        .LIVE_MASK (LIVE)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_q     (cfg_q)
    );

    strobe_phase_ctr #(
        .CNT_W  (CNT_W)
    ) u_ctr (
        .clk    (clk),
        .rst_n  (rst_n),
        .halt_i (halt_i),
        .cnt_q  (cnt_q)
    );

    // Read-back path: the register already holds zero in its reserved bits.
    always_comb begin
        rd_data_o = cfg_q;
    end

    for (genvar gi = 0; gi < WIDE_N; gi++) begin : g_wide
        localparam int LSB = WIDE_BASE + gi * FIELD_PITCH;
        strobe_tap #(
            .CNT_W  (CNT_W),
            .CODE_W (WIDE_CW),
            .SCALE  (1),
            .OFFSET (0)
        ) u_tap (
            .cnt_i  (cnt_q),
            .code_i (cfg_q[LSB +: WIDE_CW]),
            .halt_i (halt_i),
            .tick_o (tick_o[gi])
        );
    end

    for (genvar gj = 0; gj < NARROW_N; gj++) begin : g_narrow
        localparam int LSB = NARROW_BASE + gj * FIELD_PITCH;
        strobe_tap #(
            .CNT_W  (CNT_W),
            .CODE_W (NARROW_CW),
            .SCALE  (NARROW_STEP),
            .OFFSET (NARROW_OFS)
        ) u_tap (
            .cnt_i  (cnt_q),
            .code_i (cfg_q[LSB +: NARROW_CW]),
            .halt_i (halt_i),
            .tick_o (tick_o[WIDE_N + gj])
        );
    end

endmodule

// File: rtl/clk_strobe_gen_chk.sv
// Checker: timing rules of the prescaler, attached to the top by bind.
// Assumes the default layout: four taps and reserved bits 15, 14, 11 and 10.
module clk_strobe_gen_chk #(
    parameter int CNT_W = 15
) (
    input logic             clk,
    input logic             rst_n,
    input logic             halt_i,
    input logic             wr_en_i,
    input logic [15:0]      wr_data_i,
    input logic [15:0]      rd_data_o,
    input logic [3:0]       tick_o,
    input logic [CNT_W-1:0] cnt
);

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data_o & 16'hCC00) == 16'h0000); // R4

    AST_HALT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |-> tick_o == 4'b0000); // R8

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        halt_i |=> cnt == $past(cnt)); // R8

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !halt_i |=> cnt == CNT_W'($past(cnt) + 1'b1)); // R5

    AST_CODE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!halt_i && rd_data_o[3:0] == 4'd0) |-> tick_o[0]); // R6

    AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o[0] && rd_data_o[3:0] != 4'd0 && !wr_en_i) |=> !tick_o[0]); // R5

    AST_WRITE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_i |=> rd_data_o == ($past(wr_data_i) & 16'h33FF)); // R7

    AST_REG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(rd_data_o)); // R9

endmodule

bind clk_strobe_gen clk_strobe_gen_chk #(.CNT_W(15)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .halt_i    (halt_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .rd_data_o (rd_data_o),
    .tick_o    (tick_o),
    .cnt       (cnt_q)
);

// File: tb/clk_strobe_gen_bench.sv
// Bench: a scoreboard for the prescaler.
// The driver task keeps a model built from the requirements and queues the
// expected outputs. The monitor compares them shortly after each falling edge.
module clk_strobe_gen_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        halt_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [15:0] wr_data_i = 16'h0000;
    logic [15:0] rd_data_o;
    logic [3:0]  tick_o;

    int    n_checks = 0;
    int    n_fail = 0;
    bit    done = 1'b0;

    logic [3:0]  q_tick[$];
    logic [15:0] q_rd[$];
    string       q_tag[$];

    logic [14:0] ref_cnt = '0;
    logic [15:0] ref_cfg = '0;

    clk_strobe_gen u_clk_strobe_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .halt_i    (halt_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_data_o (rd_data_o),
        .tick_o    (tick_o)
    );

    always #10 clk = ~clk;

    // Strobe for exponent e: the low e bits of the counter are all ones.
    function automatic logic fires(input logic [14:0] c, input int e, input logic h);
        logic [14:0] m;
        m = '0;
        for (int b = 0; b < 15; b++) m[b] = (b < e);
        return !h && ((c & m) == m);
    endfunction

    // Expected strobes from the requirement formulas (R2, R3).
    function automatic logic [3:0] exp_tick(input logic [14:0] c, input logic [15:0] r, input logic h);
        logic [3:0] t;
        t[0] = fires(c, int'(r[3:0]), h);
        t[1] = fires(c, int'(r[7:4]), h);
        t[2] = fires(c, 2*int'(r[9:8]) + 8, h);
        t[3] = fires(c, 2*int'(r[13:12]) + 8, h);
        return t;
    endfunction

    // Driver: apply one cycle of stimulus, queue the expectation, then advance the model.
    task automatic step(input logic h, input logic we, input logic [15:0] d, input string tag);
        halt_i    = h;
        wr_en_i   = we;
        wr_data_i = d;
        q_tick.push_back(exp_tick(ref_cnt, ref_cfg, h));
        q_rd.push_back(ref_cfg);
        q_tag.push_back(tag);
        @(posedge clk);
        if (we) ref_cfg = d & 16'h33FF;
        if (!h) ref_cnt = ref_cnt + 15'd1;
        @(negedge clk);
    endtask

    task automatic run(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0000, tag);
    endtask

    // Monitor: pop the expectations and compare them with the design's outputs.
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (q_tick.size() > 0) begin
                logic [3:0]  et;
                logic [15:0] er;
                string       tg;
                et = q_tick.pop_front();
                er = q_rd.pop_front();
                tg = q_tag.pop_front();
                n_checks++;
                if (tick_o !== et) begin
                    n_fail++;
                    $display("FAIL %s tick_o got %b expected %b", tg, tick_o, et);
                end
                n_checks++;
                if (rd_data_o !== er) begin
                    n_fail++;
                    $display("FAIL %s rd_data_o got %h expected %h", tg, rd_data_o, er);
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state; R6: code 0 keeps all strobes high.
        step(1'b0, 1'b0, 16'h0000, "R1");
        run(4, "R6");
        // R7: write is visible from the next cycle; R2: wide fields with ratios 2 and 4.
        step(1'b0, 1'b1, 16'h0021, "R7");
        run(16, "R2");
        // R5: ratio 16 on tick_o[0], one cycle per period.
        step(1'b0, 1'b1, 16'h0034, "R5");
        run(40, "R5");
        // R4: reserved bits are dropped on write.
        step(1'b0, 1'b1, 16'hFFFF, "R4");
        run(6, "R4");
        step(1'b0, 1'b1, 16'hCC00, "R4");
        run(4, "R4");
        // R8: halt freezes the counter and silences strobes, including during a write.
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'h0000, "R8");
        step(1'b1, 1'b1, 16'h0012, "R8");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 16'h0000, "R8");
        run(8, "R8");
        // R3: narrow fields 256 and 16384 together with wide 32768 and 128.
        step(1'b0, 1'b1, 16'h307F, "R3");
        run(34000, "R3");
        // R3: narrow codes 1 and 2, ratios 1024 and 4096.
        step(1'b0, 1'b1, 16'h2100, "R3");
        run(4200, "R3");
        // R7: a new ratio keeps the running phase; R9: the register holds with no write.
        step(1'b0, 1'b1, 16'h0003, "R7");
        run(24, "R9");
        @(negedge clk);
        #5;
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule